// File: doc/BRIEF.md
# Byte-Paired Clock-Synthesiser Parameter File

This block stores the parameters of a programmable clock synthesiser in a file of 16-bit entries, 256 by default. A host reaches the file through a byte-wide port with three addressed locations: a read-index register, a write-index register and a data location. Each 16-bit entry is transferred as two consecutive data bytes, low byte first. A single phase state machine, shared by reads and writes, tracks which byte comes next. After the high byte, the index that was used advances by one. Host access is honoured only while the extended-enable input is high. Any other access raises a bypass strobe, so that surrounding logic can handle it.

The phase state machine has two states. `PH_LO` means the next data byte is the low byte and `PH_HI` means it is the high byte. The transition `PH_LO -> PH_HI` fires on an accepted data access in `PH_LO`. The transition `PH_HI -> PH_LO` fires on an accepted data access in `PH_HI`, and that access also advances the index it used. The transition `any -> PH_LO` fires on reset or on the clear input.

A clock-select input picks the synthesiser setting that is currently in use. Selects 0 and 1 name fixed reference clocks and bypass the file. Any other select reads the entry at index select XOR 1, which swaps selects 2 and 3. For that entry the block presents three fields combinationally: a multiplier, a divider and a post-divider shift.

Top module: `pllrf_top`

## Requirements
- R1: After reset, both index registers read 0, the phase is `PH_LO`, and every entry holds 0.
- R2: While `ext_en` is high, a write to port code 0 loads the read index and a write to port code 1 loads the write index. A read of either code returns its current value.
- R3: A data write (port code 2) stores the byte into bits [7:0] of the entry at the write index when the phase is `PH_LO`, and into bits [15:8] when it is `PH_HI`. The write index increments only after the high byte.
- R4: A data read returns bits [7:0] of the entry at the read index in `PH_LO` and bits [15:8] in `PH_HI`. The read index increments only after the high byte.
- R5: Data reads and data writes advance one shared phase. A read that directly follows a single low-byte write therefore returns a high byte.
- R6: Both index registers wrap from 255 to 0 when they increment.
- R7: A pulse on `phase_clr` returns the phase to `PH_LO` without changing either index.
- R8: While `ext_en` is low, or for port code 3, an access raises `bypass` in the same cycle and returns 0 on `host_rdata`. It changes neither the file, the indices nor the phase.
- R9: For `clk_sel` 0 or 1, `fixed_ref` is 1, `fixed_idx` equals bit 0 of the select, and all three field outputs are 0.
- R10: For any `clk_sel` of 2 or more, `fixed_ref` is 0 and the fields come from the entry at index `clk_sel` XOR 1, so select 2 reads entry 3 and select 3 reads entry 2.
- R11: From the looked-up entry, `pll_mult` is bits [6:0] plus 2, `pll_div` is bits [12:8] plus 2, and `pll_shift` is bits [15:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Extended access enable |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 2 | Port code: 0 read index, 1 write index, 2 data, 3 not decoded |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid while `host_rd` is high |
| bypass | output | 1 | Access not taken by this block |
| phase_clr | input | 1 | Returns the byte phase to low |
| clk_sel | input | SEL_W | Clock select |
| fixed_ref | output | 1 | A fixed reference clock is selected |
| fixed_idx | output | 1 | Which fixed reference is selected |
| pll_mult | output | 8 | Multiplier (entry bits [6:0] + 2) |
| pll_div | output | 6 | Divider (entry bits [12:8] + 2) |
| pll_shift | output | 3 | Post-divider shift (entry bits [15:13]) |

## Verification
Two different entries are written back to back, so that the index advance after each high byte can be seen. They are then read back in sequence. Mixing a single write byte with a read shows that both sides share one phase, and a clear pulse in the middle of an entry resets that phase. Index 255 exercises the wrap, and disabled accesses confirm that nothing was touched by reading the indices and entries back. Lookups on selects 2 and 3 hold distinct values, so a missing swap is detected, and an all-ones entry exposes field-width and offset errors.

// File: rtl/pllrf_pkg.sv
package pllrf_pkg;
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_e;

    localparam logic [1:0] PORT_RIDX = 2'd0;
    localparam logic [1:0] PORT_WIDX = 2'd1;
    localparam logic [1:0] PORT_DATA = 2'd2;

    typedef struct packed {
        logic [7:0] mult;
        logic [5:0] div;
        logic [2:0] shift;
    } pll_fields_t;
endpackage

// File: rtl/pllrf_phase_fsm.sv
module pllrf_phase_fsm
    import pllrf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  logic   step,
    output phase_e phase
);
    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LO: if (step) state_d = PH_HI;
            PH_HI: if (step) state_d = PH_LO;
            default: state_d = PH_LO;
        endcase
        if (clr) state_d = PH_LO;
    end

    assign phase = state_q;

    AST_CLR_TO_LO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase == PH_LO)); // R7
endmodule

// File: rtl/pllrf_index.sv
module pllrf_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             inc,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    idx <= '0;
        else if (load) idx <= load_val;
        else if (inc)  idx <= idx + 1'b1;
    end

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (idx == IDX_W'($past(idx) + 1'b1))); // R6
endmodule

// File: rtl/pllrf_store.sv
module pllrf_store #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wbyte,
    input  logic [IDX_W-1:0] ridx,
    output logic [15:0]      rword,
    input  logic [IDX_W-1:0] lidx,
    output logic [15:0]      lword
);
    localparam int DEPTH = 1 << IDX_W;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_lo) begin
            mem[widx][7:0] <= wbyte;
        end else if (we_hi) begin
            mem[widx][15:8] <= wbyte;
        end
    end

    assign rword = mem[ridx];
    assign lword = mem[lidx];
endmodule

// File: rtl/pllrf_lookup.sv
module pllrf_lookup
    import pllrf_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    output logic [IDX_W-1:0] lidx,
    input  logic [15:0]      lword,
    output logic             fixed_ref,
    output logic             fixed_idx,
    output pll_fields_t      fields
);
    localparam logic [IDX_W-1:0] SWAP_MASK = IDX_W'(1);

    assign fixed_ref = (clk_sel < SEL_W'(2));
    assign fixed_idx = fixed_ref & clk_sel[0];
    assign lidx      = IDX_W'(clk_sel) ^ SWAP_MASK;

    always_comb begin
        fields = '0;
        if (!fixed_ref) begin
            fields.mult  = {1'b0, lword[6:0]} + 8'd2;
            fields.div   = {1'b0, lword[12:8]} + 6'd2;
            fields.shift = lword[15:13];
        end
    end

    AST_FIELD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        !fixed_ref |-> (fields.mult >= 8'd2 && fields.div >= 6'd2)); // R11
endmodule

// File: rtl/pllrf_top.sv
module pllrf_top
    import pllrf_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_en,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             bypass,
    input  logic             phase_clr,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             fixed_ref,
    output logic             fixed_idx,
    output logic [7:0]       pll_mult,
    output logic [5:0]       pll_div,
    output logic [2:0]       pll_shift
);
    localparam int NUM_IDX = 2;

    phase_e           phase;
    logic             acc_ok, wr_ok, rd_ok, data_wr, data_rd, step;
    logic [NUM_IDX-1:0] idx_load, idx_inc;
    logic [IDX_W-1:0] idx_val [NUM_IDX];
    logic [IDX_W-1:0] ridx, widx, lidx;
    logic [15:0]      rword, lword;
    pll_fields_t      fields;

    assign acc_ok  = ext_en && (host_addr != 2'd3);
    assign wr_ok   = host_wr && acc_ok;
    assign rd_ok   = host_rd && !host_wr && acc_ok;
    assign bypass  = (host_wr || host_rd) && !acc_ok;
    assign data_wr = wr_ok && (host_addr == PORT_DATA);
    assign data_rd = rd_ok && (host_addr == PORT_DATA);
    assign step    = data_wr || data_rd;

    assign idx_load[0] = wr_ok && (host_addr == PORT_RIDX);
    assign idx_load[1] = wr_ok && (host_addr == PORT_WIDX);
    assign idx_inc[0]  = data_rd && (phase == PH_HI);
    assign idx_inc[1]  = data_wr && (phase == PH_HI);

    pllrf_phase_fsm u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (phase_clr),
        .step  (step),
        .phase (phase)
    );

    for (genvar g = 0; g < NUM_IDX; g++) begin : g_idx
        pllrf_index #(.IDX_W(IDX_W)) u_idx (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (idx_load[g]),
            .load_val (host_wdata[IDX_W-1:0]),
            .inc      (idx_inc[g]),
            .idx      (idx_val[g])
        );
    end

    assign ridx = idx_val[0];
    assign widx = idx_val[1];

    pllrf_store #(.IDX_W(IDX_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (data_wr && (phase == PH_LO)),
        .we_hi (data_wr && (phase == PH_HI)),
        .widx  (widx),
        .wbyte (host_wdata),
        .ridx  (ridx),
        .rword (rword),
        .lidx  (lidx),
        .lword (lword)
    );

    pllrf_lookup #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_lookup (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_sel   (clk_sel),
        .lidx      (lidx),
        .lword     (lword),
        .fixed_ref (fixed_ref),
        .fixed_idx (fixed_idx),
        .fields    (fields)
    );

    always_comb begin
        host_rdata = 8'h00;
        if (rd_ok) begin
            unique case (host_addr)
                PORT_RIDX: host_rdata = 8'(ridx);
                PORT_WIDX: host_rdata = 8'(widx);
                PORT_DATA: host_rdata = (phase == PH_LO) ? rword[7:0] : rword[15:8];
                default:   host_rdata = 8'h00;
            endcase
        end
    end

    assign pll_mult  = fields.mult;
    assign pll_div   = fields.div;
    assign pll_shift = fields.shift;

    AST_LO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && phase == PH_LO) |=> $stable(widx)); // R3
    AST_HI_WRITE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && phase == PH_HI) |=> (widx == IDX_W'($past(widx) + 1'b1))); // R3
    AST_HI_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && phase == PH_HI) |=> (ridx == IDX_W'($past(ridx) + 1'b1))); // R4
    AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !phase_clr) |=> ($stable(widx) && $stable(ridx) && $stable(phase))); // R8
    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |-> (host_rdata == 8'h00)); // R8
endmodule

// File: tb/pllrf_top_tb.sv
module pllrf_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_en = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       bypass;
    logic       phase_clr = 1'b0;
    logic [3:0] clk_sel = 4'd0;
    logic       fixed_ref, fixed_idx;
    logic [7:0] pll_mult;
    logic [5:0] pll_div;
    logic [2:0] pll_shift;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pllrf_top u_dut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .bypass(bypass),
        .phase_clr(phase_clr), .clk_sel(clk_sel),
        .fixed_ref(fixed_ref), .fixed_idx(fixed_idx),
        .pll_mult(pll_mult), .pll_div(pll_div), .pll_shift(pll_shift)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle host write; inputs change on the falling edge.
    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    // One-cycle host read; data sampled mid-cycle before the rising edge.
    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hread(2'd0, v); check("R1 ridx", v, 0);
        hread(2'd1, v); check("R1 widx", v, 0);
        hread(2'd2, v); check("R1 entry0 low", v, 0);
        hread(2'd2, v); check("R1 entry0 high", v, 0);
        hwrite(2'd0, 8'd0);
    endtask

    task automatic t_write_entries();
        logic [7:0] v;
        hwrite(2'd1, 8'd2);
        hread(2'd1, v); check("R2 widx load", v, 2);
        hwrite(2'd2, 8'h34);
        hread(2'd1, v); check("R3 widx held after low", v, 2);
        hwrite(2'd2, 8'h12);
        hread(2'd1, v); check("R3 widx after high", v, 3);
        hwrite(2'd2, 8'h78);
        hwrite(2'd2, 8'h56);
        hread(2'd1, v); check("R3 widx second entry", v, 4);
    endtask

    task automatic t_read_entries();
        logic [7:0] v;
        hwrite(2'd0, 8'd2);
        hread(2'd0, v); check("R2 ridx load", v, 2);
        hread(2'd2, v); check("R4 e2 low", v, 8'h34);
        hread(2'd0, v); check("R4 ridx held after low", v, 2);
        hread(2'd2, v); check("R4 e2 high", v, 8'h12);
        hread(2'd0, v); check("R4 ridx after high", v, 3);
        hread(2'd2, v); check("R4 e3 low", v, 8'h78);
        hread(2'd2, v); check("R4 e3 high", v, 8'h56);
    endtask

    task automatic t_shared_phase();
        logic [7:0] v;
        hwrite(2'd1, 8'd7);
        hwrite(2'd0, 8'd2);
        hwrite(2'd2, 8'h99);
        hread(2'd2, v); check("R5 read after one write byte is high", v, 8'h12);
        hread(2'd0, v); check("R5 ridx advanced", v, 3);
        hread(2'd1, v); check("R5 widx unchanged", v, 7);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        hwrite(2'd1, 8'd255);
        hwrite(2'd2, 8'hCD);
        hwrite(2'd2, 8'hAB);
        hread(2'd1, v); check("R6 widx wrap", v, 0);
        hwrite(2'd0, 8'd255);
        hread(2'd2, v); check("R6 e255 low", v, 8'hCD);
        hread(2'd2, v); check("R6 e255 high", v, 8'hAB);
        hread(2'd0, v); check("R6 ridx wrap", v, 0);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        hwrite(2'd1, 8'd5);
        hwrite(2'd2, 8'hAA);
        @(negedge clk); phase_clr = 1'b1;
        @(negedge clk); phase_clr = 1'b0;
        hread(2'd1, v); check("R7 widx kept", v, 5);
        hwrite(2'd2, 8'hBB);
        hwrite(2'd2, 8'hCC);
        hwrite(2'd0, 8'd5);
        hread(2'd2, v); check("R7 low rewritten", v, 8'hBB);
        hread(2'd2, v); check("R7 high", v, 8'hCC);
    endtask

    task automatic t_bypass();
        logic [7:0] v;
        @(negedge clk); ext_en = 1'b0;
        host_wr = 1'b1; host_addr = 2'd2; host_wdata = 8'hEE;
        #1 check("R8 bypass on disabled write", bypass, 1);
        @(negedge clk); host_wr = 1'b0;
        host_wr = 1'b1; host_addr = 2'd1; host_wdata = 8'h40;
        @(negedge clk); host_wr = 1'b0;
        host_rd = 1'b1; host_addr = 2'd2;
        #1 check("R8 rdata zero on disabled read", host_rdata, 0);
        @(negedge clk); host_rd = 1'b0; ext_en = 1'b1;
        hread(2'd1, v); check("R8 widx untouched", v, 6);
        hwrite(2'd0, 8'd6);
        hread(2'd2, v); check("R8 entry6 low untouched", v, 0);
        hread(2'd2, v); check("R8 phase untouched, high", v, 0);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 2'd3;
        #1 check("R8 code3 bypass", bypass, 1);
        check("R8 code3 rdata", host_rdata, 0);
        @(negedge clk); host_rd = 1'b0;
        #1 check("R8 bypass idle", bypass, 0);
    endtask

    task automatic t_lookup();
        @(negedge clk); clk_sel = 4'd0;
        #1 check("R9 sel0 fixed", fixed_ref, 1);
        check("R9 sel0 idx", fixed_idx, 0);
        check("R9 sel0 mult", pll_mult, 0);
        clk_sel = 4'd1;
        #1 check("R9 sel1 fixed", fixed_ref, 1);
        check("R9 sel1 idx", fixed_idx, 1);
        clk_sel = 4'd3;
        #1 check("R10 sel3 not fixed", fixed_ref, 0);
        check("R10 sel3 mult from e2", pll_mult, 8'h36);
        check("R10 sel3 div from e2", pll_div, 6'h14);
        check("R10 sel3 shift from e2", pll_shift, 0);
        clk_sel = 4'd2;
        #1 check("R10 sel2 mult from e3", pll_mult, 8'h7A);
        check("R11 sel2 div", pll_div, 6'h18);
        check("R11 sel2 shift", pll_shift, 2);
        hwrite(2'd1, 8'd4);
        hwrite(2'd2, 8'hFF);
        hwrite(2'd2, 8'hFF);
        clk_sel = 4'd5;
        #1 check("R11 max mult", pll_mult, 8'h81);
        check("R11 max div", pll_div, 6'h21);
        check("R11 max shift", pll_shift, 7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ext_en = 1'b1;
        t_reset();
        t_write_entries();
        t_read_entries();
        t_shared_phase();
        t_wrap();
        t_clear();
        t_bypass();
        t_lookup();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule